// File: doc/BRIEF.md
# Hardware store request controller

This block manages the shared, active-low, open-drain store/busy line of an SRAM that is backed by nonvolatile cells. The line is sampled as a request input. Whenever a store is running, the block pulls the line low through a pad output-enable. The pad can only pull the line low or release it; it never drives it high. Other devices on the same line, or the block itself through an internal trigger, can pull it low. A low level that lasts long enough becomes a request.

Once a request is accepted, new SRAM writes are blocked straight away. Reads and any write already under way may continue for a fixed grace window. At the end of that window the block starts a store through a start/done handshake with a store engine, but only if the memory has been written since the last store or recall. After the store, or after a request that needed no store, the device stays disabled until the shared line is seen high again. It then waits a recovery time before it returns to normal operation.

All delays are clock-cycle counts derived from a clock-period parameter. The raw line passes through a flop synchroniser and a pulse-width filter before it is used.

Top module: `hsr_ctrl`

## Requirements
- R1: In reset and in the first cycle after reset, `line_oe`, `wr_block`, `dev_dis` and `st_start` are all 0, and the written-since-last-store flag is clear.
- R2: A low on `line_in` that is shorter than MIN_PULSE_NS is ignored: one clock period at the defaults leaves `wr_block` and `line_oe` at 0. A low lasting two clock periods (20 ns) is accepted as a request.
- R3: An accepted request raises `line_oe` and `wr_block` together. At the defaults this happens on the 4th rising edge after the line falls, which is well inside 300 ns. `line_oe` is never 1 while `wr_block` is 0.
- R4: `st_start` rises exactly GRACE_NS/CLK_NS cycles (100 at the defaults) after `line_oe` rises. Throughout that window `dev_dis` stays 0, so reads remain allowed.
- R5: If `cyc_active` is 1 when the grace window ends, the start is postponed. `st_start` then rises on the edge after `cyc_active` is sampled 0.
- R6: If no write has happened since the last store or recall, no `st_start` is issued. At the end of the grace window `line_oe` falls to 0 and `dev_dis` rises to 1 on the same edge.
- R7: A `wr_done` pulse sets the written flag, including a write that finishes inside the grace window. The flag is cleared by `st_done` during a store or by `recall_done`. If `wr_done` and `recall_done` fall in the same cycle, the flag ends up set.
- R8: `line_oe` stays 1 from `st_start` until `st_done` is sampled. It falls on that same edge, while `dev_dis` stays 1.
- R9: After the block releases the line, `dev_dis` and `wr_block` stay 1 for as long as `line_in` is low. Once the line is high, they fall RECOVER_NS/CLK_NS cycles after the synchronised sample sees it high. At the defaults this is the 73rd rising edge after the line rises.
- R10: An `int_req` pulse while idle starts the same sequence, with `line_oe` and `wr_block` rising on the next edge.
- R11: `st_start` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Sampled level of the shared busy line (low = request/busy) |
| int_req | input | 1 | Internal store trigger pulse |
| cyc_active | input | 1 | An SRAM read or write cycle is in progress |
| wr_done | input | 1 | Pulse: an SRAM write strobe completed |
| recall_done | input | 1 | Pulse: a recall from the nonvolatile array finished |
| st_done | input | 1 | Pulse from the store engine: store complete |
| line_oe | output | 1 | Pad enable; 1 pulls the busy line low, 0 releases it |
| st_start | output | 1 | Single-cycle store start to the store engine |
| wr_block | output | 1 | New SRAM writes are inhibited |
| dev_dis | output | 1 | Device disabled for all SRAM access |

## Verification
Two pairs of events can land in the same cycle. The first pair is a completing write and a finished recall. One fights to set the written flag and the other to clear it. The bench pulses `wr_done` and `recall_done` together and then judges the outcome at the ports: the next request must produce a store. The second pair is the end of the grace window and an SRAM cycle that is still running. The bench keeps `cyc_active` high past the window end, checks that no start appears, and then checks that the start arrives on the edge after the flag drops.

// File: rtl/hsr_pkg.sv
`timescale 1ns/1ps
package hsr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GRACE,
    ST_STORE,
    ST_HOLD,
    ST_RECOV
  } hsr_state_e;

  // Round a duration up to whole clock cycles, never below one.
  function automatic int ns2cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/hsr_sync.sv
`timescale 1ns/1ps
module hsr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  // The line idles high, so every stage resets to 1.
  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/hsr_glitch.sv
`timescale 1ns/1ps
module hsr_glitch #(
  parameter int N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic hit
);
  localparam int W = (N > 1) ? $clog2(N) : 1;
  localparam logic [W-1:0] TOP = W'(N - 1);

  logic [W-1:0] run;

  // Counts consecutive low samples; saturates once the width is met.
  always_ff @(posedge clk) begin
    if (rst || din)   run <= '0;
    else if (run != TOP) run <= run + 1'b1;
  end

  assign hit = !din && (run == TOP);
endmodule

// File: rtl/hsr_tick.sv
`timescale 1ns/1ps
module hsr_tick #(
  parameter int LIMIT = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] TOP = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (cnt != TOP) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == TOP);
endmodule

// File: rtl/hsr_ctrl.sv
`timescale 1ns/1ps
module hsr_ctrl
  import hsr_pkg::*;
#(
  parameter int CLK_NS       = 10,
  parameter int GRACE_NS     = 1000,
  parameter int RECOVER_NS   = 700,
  parameter int MIN_PULSE_NS = 15,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  input  logic int_req,
  input  logic cyc_active,
  input  logic wr_done,
  input  logic recall_done,
  input  logic st_done,
  output logic line_oe,
  output logic st_start,
  output logic wr_block,
  output logic dev_dis
);
  localparam int GRACE_CYC = ns2cyc(GRACE_NS, CLK_NS);
  localparam int REC_CYC   = ns2cyc(RECOVER_NS, CLK_NS);
  localparam int FILT_CYC  = ns2cyc(MIN_PULSE_NS, CLK_NS);

  hsr_state_e st, nx;
  logic line_s, req_hit, g_done, r_done, dirty;

  hsr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(line_in), .dout(line_s)
  );

  hsr_glitch #(.N(FILT_CYC)) u_filt (
    .clk(clk), .rst(rst), .din(line_s), .hit(req_hit)
  );

  hsr_tick #(.LIMIT(GRACE_CYC)) u_grace (
    .clk(clk), .rst(rst), .run(st == ST_GRACE), .done(g_done)
  );

  hsr_tick #(.LIMIT(REC_CYC)) u_recov (
    .clk(clk), .rst(rst), .run(st == ST_RECOV), .done(r_done)
  );

  always_comb begin
    nx = st;
    unique case (st)
      ST_IDLE:  if (req_hit || int_req) nx = ST_GRACE;
      ST_GRACE: if (g_done && !cyc_active) nx = dirty ? ST_STORE : ST_HOLD;
      ST_STORE: if (st_done) nx = ST_HOLD;
      ST_HOLD:  if (line_s) nx = ST_RECOV;
      ST_RECOV: if (r_done) nx = ST_IDLE;
      default:  nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      line_oe  <= 1'b0;
      st_start <= 1'b0;
      wr_block <= 1'b0;
      dev_dis  <= 1'b0;
    end else begin
      st       <= nx;
      line_oe  <= (nx == ST_GRACE) || (nx == ST_STORE);
      st_start <= (st == ST_GRACE) && (nx == ST_STORE);
      wr_block <= (nx != ST_IDLE);
      dev_dis  <= (nx == ST_STORE) || (nx == ST_HOLD) || (nx == ST_RECOV);
    end
  end

  // Written-since-last-nonvolatile-cycle flag; a completing write wins.
  always_ff @(posedge clk) begin
    if (rst)                                          dirty <= 1'b0;
    else if (wr_done)                                 dirty <= 1'b1;
    else if ((st == ST_STORE && st_done) || recall_done) dirty <= 1'b0;
  end
endmodule

// File: rtl/hsr_ctrl_chk.sv
`timescale 1ns/1ps
module hsr_ctrl_chk
  import hsr_pkg::*;
#(
  parameter int CLK_NS  = 10,
  parameter int BUSY_NS = 300
) (
  input logic clk,
  input logic rst,
  input logic line_in,
  input logic st_done,
  input logic line_oe,
  input logic st_start,
  input logic wr_block,
  input logic dev_dis
);
  localparam int BUSY_CYC = ns2cyc(BUSY_NS, CLK_NS);
  localparam int W = $clog2(BUSY_CYC + 1);

  // Cycles the line has been low while the block is still idle.
  logic [W-1:0] low_run;
  always_ff @(posedge clk) begin
    if (rst || line_in || wr_block) low_run <= '0;
    else if (low_run != W'(BUSY_CYC)) low_run <= low_run + 1'b1;
  end

  a_r3_busy_bound: assert property (@(posedge clk) disable iff (rst)
    low_run < W'(BUSY_CYC));

  a_r3_oe_blocks: assert property (@(posedge clk) disable iff (rst)
    line_oe |-> wr_block);

  a_r8_oe_at_start: assert property (@(posedge clk) disable iff (rst)
    st_start |-> (line_oe && dev_dis));

  a_r8_release_on_done: assert property (@(posedge clk) disable iff (rst)
    (line_oe && dev_dis && st_done) |=> (!line_oe && dev_dis));

  a_r9_dis_blocks: assert property (@(posedge clk) disable iff (rst)
    dev_dis |-> wr_block);

  a_r11_pulse: assert property (@(posedge clk) disable iff (rst)
    st_start |=> !st_start);
endmodule

bind hsr_ctrl hsr_ctrl_chk #(.CLK_NS(CLK_NS)) u_chk (
  .clk(clk), .rst(rst), .line_in(line_in), .st_done(st_done),
  .line_oe(line_oe), .st_start(st_start), .wr_block(wr_block),
  .dev_dis(dev_dis)
);

// File: tb/sim_hsr_ctrl.sv
`timescale 1ns/1ps
module sim_hsr_ctrl;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_low = 1'b0, int_req = 1'b0, cyc_active = 1'b0;
  logic wr_done = 1'b0, recall_done = 1'b0, st_done = 1'b0;
  logic line_oe, st_start, wr_block, dev_dis;
  wire  line_in = !(ext_low || line_oe);

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  hsr_ctrl #(.CLK_NS(CLK_NS)) u0 (
    .clk(clk), .rst(rst), .line_in(line_in), .int_req(int_req),
    .cyc_active(cyc_active), .wr_done(wr_done), .recall_done(recall_done),
    .st_done(st_done), .line_oe(line_oe), .st_start(st_start),
    .wr_block(wr_block), .dev_dis(dev_dis)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_wr();
    wr_done = 1'b1; cyc(1); wr_done = 1'b0;
  endtask

  // External low at a negedge; hold=0 releases it after two periods.
  task automatic trig_ext(input bit hold);
    ext_low = 1'b1;
    cyc(2);
    if (!hold) ext_low = 1'b0;
    cyc(1);
    chk("R3 no drive after 3 edges", line_oe, 1'b0);
    cyc(1);
    chk("R3 drive on 4th edge", line_oe, 1'b1);
    chk("R3 writes blocked", wr_block, 1'b1);
  endtask

  // Called at the negedge right after the drive edge.
  task automatic grace_end(input bit exp_store);
    cyc(99);
    chk("R4 no start before window end", st_start, 1'b0);
    chk("R4 reads allowed in window", dev_dis, 1'b0);
    cyc(1);
    if (exp_store) begin
      chk("R4 start at window end", st_start, 1'b1);
      chk("R8 drive held at start", line_oe, 1'b1);
    end else begin
      chk("R6 no start when clean", st_start, 1'b0);
      chk("R6 drive released", line_oe, 1'b0);
    end
    chk("R6 disabled after window", dev_dis, 1'b1);
  endtask

  task automatic finish_store();
    cyc(1);
    chk("R11 start is one cycle", st_start, 1'b0);
    cyc(8);
    chk("R8 drive held during store", line_oe, 1'b1);
    st_done = 1'b1; cyc(1); st_done = 1'b0;
    chk("R8 released on done", line_oe, 1'b0);
    chk("R8 still disabled", dev_dis, 1'b1);
  endtask

  // Called at the negedge after which the line is high.
  task automatic recover_chk();
    cyc(72);
    chk("R9 disabled before recovery ends", dev_dis, 1'b1);
    chk("R9 writes blocked in recovery", wr_block, 1'b1);
    cyc(1);
    chk("R9 enabled after recovery", dev_dis, 1'b0);
    chk("R9 writes allowed after recovery", wr_block, 1'b0);
  endtask

  task automatic t_reset();
    rst = 1'b1; cyc(3);
    chk("R1 oe in reset", line_oe, 1'b0);
    chk("R1 block in reset", wr_block, 1'b0);
    rst = 1'b0; cyc(1);
    chk("R1 oe after reset", line_oe, 1'b0);
    chk("R1 dis after reset", dev_dis, 1'b0);
    chk("R1 start after reset", st_start, 1'b0);
    chk("R1 block after reset", wr_block, 1'b0);
  endtask

  task automatic t_glitch();
    logic seen = 1'b0;
    ext_low = 1'b1; cyc(1); ext_low = 1'b0;
    for (int i = 0; i < 10; i++) begin
      if (wr_block || line_oe) seen = 1'b1;
      cyc(1);
    end
    chk("R2 short pulse ignored", seen, 1'b0);
    trig_ext(1'b0);
    grace_end(1'b0);
    recover_chk();
  endtask

  task automatic t_store_then_clean();
    pulse_wr();
    trig_ext(1'b0);
    grace_end(1'b1);
    finish_store();
    recover_chk();
    trig_ext(1'b0);
    grace_end(1'b0);  // R7 flag cleared by store
    recover_chk();
  endtask

  task automatic t_write_in_grace();
    trig_ext(1'b0);
    cyc_active = 1'b1;
    pulse_wr();
    cyc(98);
    chk("R5 no start at window minus one", st_start, 1'b0);
    cyc(1);
    chk("R5 start postponed by active cycle", st_start, 1'b0);
    chk("R5 drive kept while postponed", line_oe, 1'b1);
    cyc(4);
    cyc_active = 1'b0;
    cyc(1);
    chk("R7 grace write makes store run", st_start, 1'b1);
    finish_store();
    recover_chk();
  endtask

  task automatic t_ext_hold();
    trig_ext(1'b1);
    grace_end(1'b0);
    cyc(20);
    chk("R9 disabled while line held low", dev_dis, 1'b1);
    chk("R9 blocked while line held low", wr_block, 1'b1);
    ext_low = 1'b0;
    recover_chk();
  endtask

  task automatic t_int_req();
    pulse_wr();
    int_req = 1'b1; cyc(1); int_req = 1'b0;
    chk("R10 internal trigger drives line", line_oe, 1'b1);
    chk("R10 internal trigger blocks writes", wr_block, 1'b1);
    grace_end(1'b1);
    finish_store();
    recover_chk();
  endtask

  task automatic t_same_cycle();
    wr_done = 1'b1; recall_done = 1'b1; cyc(1);
    wr_done = 1'b0; recall_done = 1'b0;
    trig_ext(1'b0);
    grace_end(1'b1);  // R7 write wins over recall
    finish_store();
    recover_chk();
    pulse_wr();
    recall_done = 1'b1; cyc(1); recall_done = 1'b0;
    trig_ext(1'b0);
    grace_end(1'b0);  // R7 recall clears flag
    recover_chk();
  endtask

  initial begin
    #(200000 * CLK_NS);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_glitch();
    t_store_then_clean();
    t_write_in_grace();
    t_ext_hold();
    t_int_req();
    t_same_cycle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule